// File: doc/BRIEF.md
# Multi-Mode Clock Enable Generator

This block turns one master clock into four clock-enable pulse trains: one for the pixel serializer, one for the memory controller, one for the processor and one for the raster sync/timing generator. A 2-bit mode switch picks how fast the first three run. The sync/timing domain keeps the same nominal rate in every mode. The master clock stands for the fastest domain rate. Each enable is a one-cycle pulse that the receiving logic uses in place of a separate clock.

Four switch codes are decoded:
- **Stock** keeps the original 4:2:1 ladder at half speed.
- **Double-processor** doubles only memory and processor.
- **Double-video** doubles serializer, memory and processor.
- **Fractional** runs the doubled ladder and makes the sync enable from 5/8 of the processor rate. A small accumulator does this, so the sync rate stays nominal when the master clock is scaled down to 51.2 MHz.

The switch is asynchronous. It passes through a two-flop synchronizer. The mode state machine commits a new mode only on a safe boundary, which is the cycle before the phase counter wraps to zero while the accumulator is empty. Every domain therefore starts the new mode aligned.

The mode register has four states: `MODE_STOCK`, `MODE_DBLCPU`, `MODE_DBLVID` and `MODE_FRAC`. There are two transitions out of any state:
- **HOLD** keeps the state when no boundary is reached or the request equals the state.
- **SWITCH** loads the requested state on a boundary when the request differs.

Top module: `clkgen_mode_top`

## Requirements
- R1: While reset is high, all four enables are low. Reset selects stock mode and clears the phase counter and accumulator, so the first cycle after reset falls has all four enables high.
- R2: In stock mode (switch code 00), relative to phase counter zero:
  - video enable fires every 2 master cycles;
  - memory enable fires every 4 master cycles;
  - processor enable fires every 8 master cycles;
  - sync enable fires every 8 master cycles.
- R3: In double-processor mode (code 01), relative to phase zero:
  - video enable fires every 2 cycles;
  - memory enable fires every 2 cycles;
  - processor enable fires every 4 cycles;
  - sync enable fires every 8 cycles.
- R4: In double-video mode (code 10), relative to phase zero:
  - video enable fires every cycle;
  - memory enable fires every 2 cycles;
  - processor enable fires every 4 cycles;
  - sync enable fires every 8 cycles.
- R5: In fractional mode (code 11), video, memory and processor enables behave as in R4. The sync enable fires only on a processor tick where the accumulator plus 5 reaches 8 or more; the accumulator keeps the sum modulo 8. Starting from an empty accumulator, this gives 5 sync pulses per 8 processor ticks in the order no, yes, no, yes, yes, no, yes, yes.
- R6: The sync enable never fires in a cycle without the processor enable. The memory enable never fires without the video enable, and the processor enable never fires without the memory enable.
- R7: A switch value reaches the mode logic after two synchronizer flops. It takes effect only on a boundary: the phase counter is at its last value (7) and the accumulator is zero, so the new mode starts at phase zero. Until then the previous mode's pattern continues. Outside fractional mode the accumulator stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (fastest domain rate) |
| rst | input | 1 | Synchronous reset, active high |
| mode_sw | input | 2 | Asynchronous mode switches: 00 stock, 01 double-processor, 10 double-video, 11 fractional |
| vid_en | output | 1 | Pixel serializer clock enable |
| mem_en | output | 1 | Memory controller clock enable |
| cpu_en | output | 1 | Processor clock enable |
| sync_en | output | 1 | Sync/timing generator clock enable |

## Verification
The hardest case to reach is a switch change that lands while the fractional accumulator holds a non-zero value. The block must then wait for a later phase wrap before it leaves fractional mode. A switch that flips twice before the synchronized request is committed is also hard to reach, because only the last value may take effect. The stimulus changes the switch at phase offsets that are not multiples of the period, and leaves fractional mode a few cycles after entering it. It flips the switch for two cycles and then moves to another code. It also asserts reset while fractional mode runs with the switch still set to 11, so the return to fractional mode after reset follows the synchronizer and boundary rules again.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [1:0] {
        MODE_STOCK  = 2'b00,
        MODE_DBLCPU = 2'b01,
        MODE_DBLVID = 2'b10,
        MODE_FRAC   = 2'b11
    } mode_e;

endpackage

// File: rtl/clk_mode_sync.sv
module clk_mode_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
    import clkmode_pkg::*;
#(
    parameter int PHASE_W = 3,
    parameter int LG_W    = $clog2(PHASE_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_req,
    input  logic            boundary,
    output mode_e           mode_q,
    output logic [LG_W-1:0] vid_lg,
    output logic [LG_W-1:0] mem_lg,
    output logic [LG_W-1:0] cpu_lg,
    output logic            frac_on
);

    localparam logic [LG_W-1:0] LG_SLOW_VID = LG_W'(PHASE_W - 2);
    localparam logic [LG_W-1:0] LG_SLOW_MEM = LG_W'(PHASE_W - 1);
    localparam logic [LG_W-1:0] LG_SLOW_CPU = LG_W'(PHASE_W);
    localparam logic [LG_W-1:0] LG_FAST_VID = LG_W'(PHASE_W - 3);
    localparam logic [LG_W-1:0] LG_FAST_MEM = LG_W'(PHASE_W - 2);
    localparam logic [LG_W-1:0] LG_FAST_CPU = LG_W'(PHASE_W - 1);

    mode_e state, state_nx;
    logic  do_switch;

    assign do_switch = boundary && (mode_req != state);

    // next-state decision: HOLD or SWITCH from every state
    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_STOCK:  if (do_switch) state_nx = mode_e'(mode_req);
            MODE_DBLCPU: if (do_switch) state_nx = mode_e'(mode_req);
            MODE_DBLVID: if (do_switch) state_nx = mode_e'(mode_req);
            MODE_FRAC:   if (do_switch) state_nx = mode_e'(mode_req);
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= MODE_STOCK;
        else     state <= state_nx;
    end

    // outputs per state
    always_comb begin
        vid_lg  = LG_SLOW_VID;
        mem_lg  = LG_SLOW_MEM;
        cpu_lg  = LG_SLOW_CPU;
        frac_on = 1'b0;
        unique case (state)
            MODE_STOCK: begin
                vid_lg = LG_SLOW_VID;
                mem_lg = LG_SLOW_MEM;
                cpu_lg = LG_SLOW_CPU;
            end
            MODE_DBLCPU: begin
                vid_lg = LG_SLOW_VID;
                mem_lg = LG_FAST_MEM;
                cpu_lg = LG_FAST_CPU;
            end
            MODE_DBLVID: begin
                vid_lg = LG_FAST_VID;
                mem_lg = LG_FAST_MEM;
                cpu_lg = LG_FAST_CPU;
            end
            MODE_FRAC: begin
                vid_lg  = LG_FAST_VID;
                mem_lg  = LG_FAST_MEM;
                cpu_lg  = LG_FAST_CPU;
                frac_on = 1'b1;
            end
        endcase
    end

    assign mode_q = state;

    // R7
    switch_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> $past(boundary));

    // R1
    reset_to_stock_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == MODE_STOCK));

endmodule

// File: rtl/clk_phase_div.sv
module clk_phase_div #(
    parameter int PHASE_W = 3,
    parameter int LG_W    = $clog2(PHASE_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LG_W-1:0] vid_lg,
    input  logic [LG_W-1:0] mem_lg,
    input  logic [LG_W-1:0] cpu_lg,
    output logic            vid_tick,
    output logic            mem_tick,
    output logic            cpu_tick,
    output logic            base_sync_tick,
    output logic            wrap
);

    localparam logic [PHASE_W-1:0] PH_ONE  = PHASE_W'(1);
    localparam logic [PHASE_W-1:0] PH_LAST = '1;

    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] vid_mask, mem_mask, cpu_mask;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + PH_ONE;
    end

    always_comb begin
        for (int i = 0; i < PHASE_W; i++) begin
            vid_mask[i] = (i < int'(vid_lg));
            mem_mask[i] = (i < int'(mem_lg));
            cpu_mask[i] = (i < int'(cpu_lg));
        end
    end

    assign vid_tick       = ((phase & vid_mask) == '0);
    assign mem_tick       = ((phase & mem_mask) == '0);
    assign cpu_tick       = ((phase & cpu_mask) == '0);
    assign base_sync_tick = (phase == '0);
    assign wrap           = (phase == PH_LAST);

    // R6
    mem_implies_vid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_tick |-> vid_tick);

    // R6
    cpu_implies_mem_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_tick |-> mem_tick);

endmodule

// File: rtl/clk_frac_acc.sv
module clk_frac_acc #(
    parameter int ACC_W = 3,
    parameter int STEP  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic frac_on,
    input  logic cpu_tick,
    output logic carry,
    output logic idle
);

    localparam logic [ACC_W:0] STEP_V = (ACC_W + 1)'(STEP);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic             adv;

    assign adv = frac_on && cpu_tick;
    assign sum = {1'b0, acc} + STEP_V;

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (adv) acc <= sum[ACC_W-1:0];
    end

    assign carry = adv && sum[ACC_W];
    assign idle  = (acc == '0);

    // R7
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !frac_on |-> idle);

endmodule

// File: rtl/clkgen_mode_top.sv
module clkgen_mode_top
    import clkmode_pkg::*;
#(
    parameter int PHASE_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ACC_W       = 3,
    parameter int FRAC_STEP   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sw,
    output logic       vid_en,
    output logic       mem_en,
    output logic       cpu_en,
    output logic       sync_en
);

    localparam int LG_W = $clog2(PHASE_W + 1);

    logic [1:0]      mode_req;
    mode_e           mode_q;
    logic [LG_W-1:0] vid_lg, mem_lg, cpu_lg;
    logic            frac_on;
    logic            vid_tick, mem_tick, cpu_tick, base_sync_tick, wrap;
    logic            carry, idle, boundary;

    clk_mode_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (mode_sw),
        .sync_out (mode_req)
    );

    clk_mode_fsm #(.PHASE_W(PHASE_W), .LG_W(LG_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_req),
        .boundary (boundary),
        .mode_q   (mode_q),
        .vid_lg   (vid_lg),
        .mem_lg   (mem_lg),
        .cpu_lg   (cpu_lg),
        .frac_on  (frac_on)
    );

    clk_phase_div #(.PHASE_W(PHASE_W), .LG_W(LG_W)) u_div (
        .clk            (clk),
        .rst            (rst),
        .vid_lg         (vid_lg),
        .mem_lg         (mem_lg),
        .cpu_lg         (cpu_lg),
        .vid_tick       (vid_tick),
        .mem_tick       (mem_tick),
        .cpu_tick       (cpu_tick),
        .base_sync_tick (base_sync_tick),
        .wrap           (wrap)
    );

    clk_frac_acc #(.ACC_W(ACC_W), .STEP(FRAC_STEP)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .frac_on  (frac_on),
        .cpu_tick (cpu_tick),
        .carry    (carry),
        .idle     (idle)
    );

    assign boundary = wrap && idle;

    assign vid_en  = !rst && vid_tick;
    assign mem_en  = !rst && mem_tick;
    assign cpu_en  = !rst && cpu_tick;
    assign sync_en = !rst && (frac_on ? carry : base_sync_tick);

    // R6
    sync_implies_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        sync_en |-> cpu_en);

    // R4
    fast_video_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DBLVID) |-> vid_en);

    // R2
    stock_sync_with_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STOCK) |-> (cpu_en == sync_en));

endmodule

// File: tb/sim_clkgen_mode_top.sv
module sim_clkgen_mode_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sw  = 2'b00;
    logic       vid_en, mem_en, cpu_en, sync_en;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    logic [3:0] q_exp [$];
    string      q_tag [$];

    int m_s1 = 0, m_s2 = 0, m_mode = 0, m_cnt = 0, m_acc = 0;
    bit m_first = 1'b0;

    always #2 clk = ~clk;

    clkgen_mode_top u0 (
        .clk     (clk),
        .rst     (rst),
        .mode_sw (sw),
        .vid_en  (vid_en),
        .mem_en  (mem_en),
        .cpu_en  (cpu_en),
        .sync_en (sync_en)
    );

    function automatic logic [3:0] expect_vec();
        int vp, mp, cp;
        logic v, m, c, s;
        if (rst) return 4'b0000;
        case (m_mode)
            0:       begin vp = 2; mp = 4; cp = 8; end
            1:       begin vp = 2; mp = 2; cp = 4; end
            default: begin vp = 1; mp = 2; cp = 4; end
        endcase
        v = (m_cnt % vp) == 0;
        m = (m_cnt % mp) == 0;
        c = (m_cnt % cp) == 0;
        if (m_mode == 3) s = c && (m_acc + 5 >= 8);
        else             s = (m_cnt == 0);
        return {v, m, c, s};
    endfunction

    function automatic string expect_tag();
        if (rst || m_first)  return "R1";
        if (m_s2 != m_mode)  return "R7";
        case (m_mode)
            0:       return "R2";
            1:       return "R3";
            2:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step(input logic [1:0] sw_n, input logic rst_in);
        int cpu_p;
        bit tick;
        @(posedge clk);
        #1;
        m_first = 1'b0;
        if (rst) begin
            m_first = !rst_in;
            m_s1 = 0; m_s2 = 0; m_mode = 0; m_cnt = 0; m_acc = 0;
        end else begin
            int nmode, nacc;
            cpu_p = (m_mode == 0) ? 8 : 4;
            tick  = (m_cnt % cpu_p) == 0;
            nacc  = (m_mode == 3 && tick) ? (m_acc + 5) % 8 : m_acc;
            nmode = (m_cnt == 7 && m_acc == 0) ? m_s2 : m_mode;
            m_s2   = m_s1;
            m_s1   = int'(sw);
            m_cnt  = (m_cnt + 1) % 8;
            m_acc  = nacc;
            m_mode = nmode;
        end
        sw  = sw_n;
        rst = rst_in;
        q_exp.push_back(expect_vec());
        q_tag.push_back(expect_tag());
    endtask

    task automatic run(input logic [1:0] sw_n, input int n);
        for (int i = 0; i < n; i++) step(sw_n, 1'b0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [3:0] e, got;
            string t;
            e   = q_exp.pop_front();
            t   = q_tag.pop_front();
            got = {vid_en, mem_en, cpu_en, sync_en};
            compared++;
            if (got !== e) begin
                mismatched++;
                $display("FAIL %s: {vid,mem,cpu,sync} actual %b expected %b at %0t",
                         t, got, e, $time);
            end
            // R6: sync pulse only together with processor pulse
            compared++;
            if (sync_en && !cpu_en) begin
                mismatched++;
                $display("FAIL R6: sync_en actual 1 with cpu_en 0, expected sync_en 0");
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low, then stock starts at phase zero
        step(2'b00, 1'b1);
        step(2'b00, 1'b1);
        step(2'b00, 1'b0);
        run(2'b00, 40);     // R2
        run(2'b01, 37);     // R3 with change mid-period, R7
        run(2'b10, 45);     // R4
        run(2'b11, 70);     // R5
        run(2'b00, 9);      // leave fractional with accumulator busy, R7
        run(2'b00, 60);
        run(2'b01, 2);      // short flip then a different code, R7
        run(2'b10, 50);
        run(2'b11, 45);
        step(2'b11, 1'b1);  // reset during fractional mode, R1
        step(2'b11, 1'b1);
        step(2'b11, 1'b0);
        run(2'b11, 80);
        run(2'b01, 5);
        run(2'b00, 40);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule